// File: doc/BRIEF.md
# Audio Sample Word to Subframe Formatter

This block converts 32-bit words taken from a transmit data FIFO into the fields of one digital-audio subframe: a 4-bit preamble code, a 4-bit auxiliary field, a 20-bit audio field, and the validity, user, channel-status and parity bits. A biphase serializer downstream consumes these fields. Both sides use a valid/ready handshake.

A 2-bit width selector picks the mode. Three modes place a justified sample of 16, 20 or 24 bits into the 24-bit aux+audio slot. The raw mode takes every subframe field straight from the word. A packing flag, which is only honoured with 16-bit width, carries two samples in one word, and such a word produces two subframes in a row. The width, the packing flag and the two side bits are captured together with the word. A configuration change therefore never alters a word that is already held.

Top module: `audio_subframe_fmt`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Width code 2'b00 (16-bit, unpacked) gives audio = {word[15:0], 4'h0} and aux = 0. Bits 31:16 are ignored.
- R3: Width code 2'b01 (20-bit) gives audio = word[19:0] and aux = 0. Bits 31:20 are ignored.
- R4: Width code 2'b10 (24-bit) gives audio = word[23:4] and aux = word[3:0]. Bits 31:24 are ignored.
- R5: Width code 2'b11 (raw) gives parity = word[31], channel status = word[30], user = word[29], validity = word[28], audio = word[27:8], aux = word[7:4] and preamble = word[3:0].
- R6: In width codes 00, 01 and 10, the preamble code is 0 and validity is 0. User and channel status equal ext_user and ext_chstat as sampled when the word was accepted.
- R7: In width codes 00, 01 and 10, the parity bit makes the count of ones over aux, audio, validity, user, channel status and parity even.
- R8: With cfg_pack = 1 and width code 00, a word yields two subframes. The first carries word[15:0] (left) and the second carries word[31:16] (right), each placed as in R2.
- R9: With a width code other than 00, cfg_pack is ignored and each word yields exactly one subframe.
- R10: in_ready is 1 only when no word is held, or when the last subframe of the held word is being taken in the same cycle. While out_valid is 1 and out_ready is 0, every output field holds its value.
- R11: The width, the packing flag and the side bits are captured when a word is accepted. A later change to cfg_width, cfg_pack, ext_user or ext_chstat does not affect the subframes of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | 2 | Width mode: 00 16-bit, 01 20-bit, 10 24-bit, 11 raw |
| cfg_pack | input | 1 | Two 16-bit samples per word (width 00 only) |
| ext_user | input | 1 | User bit for non-raw modes |
| ext_chstat | input | 1 | Channel-status bit for non-raw modes |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when valid |
| in_word | input | 32 | FIFO word |
| out_valid | output | 1 | Subframe fields valid |
| out_ready | input | 1 | Serializer takes the subframe |
| out_preamble | output | 4 | Preamble code |
| out_aux | output | 4 | Auxiliary field |
| out_audio | output | 20 | Audio field |
| out_valid_bit | output | 1 | Validity bit |
| out_user | output | 1 | User bit |
| out_chstat | output | 1 | Channel-status bit |
| out_parity | output | 1 | Parity bit |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 20-bit audio field, and 4-bit aux and preamble fields. These values reach every width code, the raw field positions and both halves of a packed word.

Words are sent with the output always ready, with the output ready every other cycle, and with the output held off. Held-off phases expose output stability, the blocked input while a packed word's left half is pending, and a configuration change made while a word is held.

// File: rtl/sfmt_pkg.sv
// Package: shared field widths, width-mode codes and the subframe field record.
package sfmt_pkg;

    localparam int WORD_W  = 32;
    localparam int AUDIO_W = 20;
    localparam int AUX_W   = 4;
    localparam int PRE_W   = 4;
    localparam int HALF_W  = WORD_W / 2;
    localparam int SLOT_W  = AUDIO_W + AUX_W;

    typedef enum logic [1:0] {
        WM_16  = 2'b00,
        WM_20  = 2'b01,
        WM_24  = 2'b10,
        WM_RAW = 2'b11
    } width_mode_e;

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [AUX_W-1:0]   aux;
        logic [AUDIO_W-1:0] audio;
        logic               vbit;
        logic               ubit;
        logic               cbit;
        logic               par;
    } sf_fields_t;

endpackage

// File: rtl/sfmt_hold.sv
// Module: sfmt_hold
// Holds one accepted word together with its captured configuration. It also
// tracks which half of a packed word is presented.
// Assumes: packing is valid only with the 16-bit width code; otherwise the
// flag is dropped at capture.
module sfmt_hold
    import sfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_pack,
    input  logic              ext_user,
    input  logic              ext_chstat,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              out_ready,
    output logic              full_q,
    output logic              half_q,
    output logic [WORD_W-1:0] word_q,
    output width_mode_e       width_q,
    output logic              pack_q,
    output logic              user_q,
    output logic              chstat_q
);

    logic last_part;
    logic take_in;
    logic take_out;

    // Marks the subframe now on the output as the final one of the held word.
    always_comb last_part = !pack_q || half_q;

    // Accept a word when empty or when the final subframe leaves this cycle.
    always_comb in_ready = !full_q || (out_ready && last_part);

    // Handshake events on both sides.
    always_comb begin
        take_in  = in_valid && in_ready;
        take_out = full_q && out_ready;
    end

    // Holding register: load on accept, advance half or empty on consume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q   <= 1'b0;
            half_q   <= 1'b0;
            word_q   <= '0;
            width_q  <= WM_16;
            pack_q   <= 1'b0;
            user_q   <= 1'b0;
            chstat_q <= 1'b0;
        end else if (take_in) begin
            full_q   <= 1'b1;
            half_q   <= 1'b0;
            word_q   <= in_word;
            width_q  <= width_mode_e'(cfg_width);
            pack_q   <= cfg_pack && (cfg_width == WM_16);
            user_q   <= ext_user;
            chstat_q <= ext_chstat;
        end else if (take_out) begin
            if (last_part) begin
                full_q <= 1'b0;
                half_q <= 1'b0;
            end else begin
                half_q <= 1'b1;
            end
        end
    end

    // R10: a stalled output keeps its word and half selection.
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        full_q && !out_ready |=> full_q && $stable(word_q) && $stable(half_q));

    // R8: leaving the left half of a packed word presents the right half next.
    a_r8_second_half: assert property (@(posedge clk) disable iff (!rst_n)
        full_q && out_ready && pack_q && !half_q
        |=> full_q && half_q && $stable(word_q));

    // R9: packing is never active with a width other than 16-bit.
    a_r9_pack_16_only: assert property (@(posedge clk) disable iff (!rst_n)
        full_q && (width_q != WM_16) |-> !pack_q);

endmodule

// File: rtl/sfmt_map.sv
// Module: sfmt_map
// Places the held word into subframe fields for the captured width mode.
// Assumes: the parity for non-raw modes is added by the caller.
module sfmt_map
    import sfmt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  width_mode_e       width,
    input  logic              pack,
    input  logic              half,
    input  logic              user,
    input  logic              chstat,
    output sf_fields_t        fields,
    output logic              is_raw
);

    localparam int PAD16 = SLOT_W - HALF_W;
    localparam int PAD20 = SLOT_W - AUDIO_W;

    logic [HALF_W-1:0] s16;
    logic [SLOT_W-1:0] slot;

    // Picks the 16-bit sample: right half only for the second packed subframe.
    always_comb s16 = (pack && half) ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];

    // Builds the MSB-aligned 24-bit aux+audio slot for the justified modes.
    always_comb begin
        case (width)
            WM_16:   slot = {s16, {PAD16{1'b0}}};
            WM_20:   slot = {word[AUDIO_W-1:0], {PAD20{1'b0}}};
            default: slot = word[SLOT_W-1:0];
        endcase
    end

    // Fills every field: straight from the word in raw mode, from the slot otherwise.
    always_comb begin
        is_raw = (width == WM_RAW);
        if (is_raw) begin
            fields.par   = word[31];
            fields.cbit  = word[30];
            fields.ubit  = word[29];
            fields.vbit  = word[28];
            fields.audio = word[27:8];
            fields.aux   = word[7:4];
            fields.pre   = word[3:0];
        end else begin
            fields.par   = 1'b0;
            fields.cbit  = chstat;
            fields.ubit  = user;
            fields.vbit  = 1'b0;
            fields.audio = slot[SLOT_W-1:AUX_W];
            fields.aux   = slot[AUX_W-1:0];
            fields.pre   = '0;
        end
    end

endmodule

// File: rtl/sfmt_parity.sv
// Module: sfmt_parity
// Computes the bit that makes a vector plus that bit hold an even count of ones.
// Assumes: N of at least 1. The XOR tree is built stage by stage.
module sfmt_parity #(
    parameter int N = 27
) (
    input  logic [N-1:0] bits,
    output logic         par
);

    logic [N-1:0] acc;

    assign acc[0] = bits[0];
    generate
        for (genvar i = 1; i < N; i++) begin : g_chain
            assign acc[i] = acc[i-1] ^ bits[i];
        end
    endgenerate

    // The last stage is the odd/even indicator itself.
    always_comb par = acc[N-1];

endmodule

// File: rtl/audio_subframe_fmt.sv
// Module: audio_subframe_fmt
// Top: turns transmit FIFO words into subframe fields, one or two per word.
// Assumes: the serializer downstream takes a subframe whenever out_ready is high.
module audio_subframe_fmt
    import sfmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_width,
    input  logic               cfg_pack,
    input  logic               ext_user,
    input  logic               ext_chstat,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PRE_W-1:0]   out_preamble,
    output logic [AUX_W-1:0]   out_aux,
    output logic [AUDIO_W-1:0] out_audio,
    output logic               out_valid_bit,
    output logic               out_user,
    output logic               out_chstat,
    output logic               out_parity
);

    localparam int PAR_N = AUX_W + AUDIO_W + 3;

    logic              full_q;
    logic              half_q;
    logic [WORD_W-1:0] word_q;
    width_mode_e       width_q;
    logic              pack_q;
    logic              user_q;
    logic              chstat_q;
    sf_fields_t        mapped;
    logic              is_raw;
    logic              calc_par;

    sfmt_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_width  (cfg_width),
        .cfg_pack   (cfg_pack),
        .ext_user   (ext_user),
        .ext_chstat (ext_chstat),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .out_ready  (out_ready),
        .full_q     (full_q),
        .half_q     (half_q),
        .word_q     (word_q),
        .width_q    (width_q),
        .pack_q     (pack_q),
        .user_q     (user_q),
        .chstat_q   (chstat_q)
    );

    sfmt_map u_map (
        .word   (word_q),
        .width  (width_q),
        .pack   (pack_q),
        .half   (half_q),
        .user   (user_q),
        .chstat (chstat_q),
        .fields (mapped),
        .is_raw (is_raw)
    );

    sfmt_parity #(.N(PAR_N)) u_par (
        .bits ({mapped.aux, mapped.audio, mapped.vbit, mapped.ubit, mapped.cbit}),
        .par  (calc_par)
    );

    // Drives the output fields; parity comes from the word in raw mode.
    always_comb begin
        out_valid     = full_q;
        out_preamble  = mapped.pre;
        out_aux       = mapped.aux;
        out_audio     = mapped.audio;
        out_valid_bit = mapped.vbit;
        out_user      = mapped.ubit;
        out_chstat    = mapped.cbit;
        out_parity    = is_raw ? mapped.par : calc_par;
    end

    // R7: in the justified modes the subframe bits 4..31 hold an even count of ones.
    a_r7_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (width_q != WM_RAW)
        |-> ($countones({out_aux, out_audio, out_valid_bit, out_user,
                         out_chstat, out_parity}) % 2) == 0);

    // R6: the justified modes drive validity and preamble code to zero.
    a_r6_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (width_q != WM_RAW) |-> !out_valid_bit && (out_preamble == '0));

    // R10: stalled output fields stay put.
    a_r10_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready
        |=> out_valid && $stable(out_audio) && $stable(out_aux) && $stable(out_parity));

    // R1: out_valid is low on the cycle after reset.
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: tb/audio_subframe_fmt_tb_top.sv
// Scoreboard bench: a driver task queues expected subframes; a monitor compares them.
module audio_subframe_fmt_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'b00;
    logic        cfg_pack = 1'b0;
    logic        ext_user = 1'b0;
    logic        ext_chstat = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_preamble;
    logic [3:0]  out_aux;
    logic [19:0] out_audio;
    logic        out_valid_bit;
    logic        out_user;
    logic        out_chstat;
    logic        out_parity;

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          done = 1'b0;
    bit          hold_low = 1'b1;
    bit          alt_rdy = 1'b0;
    logic [31:0] expq[$];
    string       tagq[$];

    audio_subframe_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_pack(cfg_pack),
        .ext_user(ext_user), .ext_chstat(ext_chstat), .in_valid(in_valid),
        .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
        .out_ready(out_ready), .out_preamble(out_preamble), .out_aux(out_aux),
        .out_audio(out_audio), .out_valid_bit(out_valid_bit), .out_user(out_user),
        .out_chstat(out_chstat), .out_parity(out_parity)
    );

    always #5 clk = ~clk;

    // Output ready pattern, updated just after each rising edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        out_ready = hold_low ? 1'b0 : (alt_rdy ? cyc[0] : 1'b1);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected subframe record {pre,aux,audio,v,u,c,p}, computed from the requirements.
    function automatic logic [31:0] model(input logic [31:0] w, input logic [1:0] wd,
                                          input bit pk, input bit hf, input bit u, input bit c);
        logic [3:0]  pre = 4'h0;
        logic [3:0]  aux = 4'h0;
        logic [19:0] au  = '0;
        logic        v = 1'b0, p = 1'b0;
        int          ones = 0;
        case (wd)
            2'b00: au = {(pk && hf) ? w[31:16] : w[15:0], 4'h0};
            2'b01: au = w[19:0];
            2'b10: begin au = w[23:4]; aux = w[3:0]; end
            default: ;
        endcase
        if (wd == 2'b11)
            return {w[3:0], w[7:4], w[27:8], w[28], w[29], w[30], w[31]};
        for (int i = 0; i < 4; i++) ones += aux[i];
        for (int i = 0; i < 20; i++) ones += au[i];
        ones += u + c;
        p = ones[0];
        return {pre, aux, au, v, u, c, p};
    endfunction

    // Driver: presents one word, waits for acceptance, queues its subframes.
    task automatic send(input logic [31:0] w, input bit u, input bit c, input string tag);
        bit pk;
        pk = cfg_pack && (cfg_width == 2'b00);
        in_valid = 1'b1; in_word = w; ext_user = u; ext_chstat = c;
        while (!in_ready) @(negedge clk);
        expq.push_back(model(w, cfg_width, pk, 1'b0, u, c)); tagq.push_back(tag);
        if (pk) begin
            expq.push_back(model(w, cfg_width, pk, 1'b1, u, c)); tagq.push_back(tag);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0 || out_valid) @(negedge clk);
    endtask

    // Monitor: compares every consumed subframe against the queue front.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check("R9 unexpected subframe", 32'h1, 32'h0);
            end else begin
                string t;
                logic [31:0] e;
                e = expq.pop_front();
                t = tagq.pop_front();
                check(t, {out_preamble, out_aux, out_audio, out_valid_bit, out_user,
                          out_chstat, out_parity}, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [19:0] held;
        repeat (3) @(negedge clk);
        check("R1 out_valid after reset", {31'b0, out_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready after reset", {31'b0, in_ready}, 32'h1);
        check("R1 out_valid idle", {31'b0, out_valid}, 32'h0);
        hold_low = 1'b0;

        // R2 R6 R7: 16-bit justified, always ready.
        cfg_width = 2'b00; cfg_pack = 1'b0;
        send(32'hABCD_1234, 1'b1, 1'b0, "R2 16-bit a");
        send(32'h0000_FFFF, 1'b0, 1'b1, "R2 16-bit b R7");
        send(32'hFFFF_8001, 1'b1, 1'b1, "R2 16-bit c R6");
        drain();

        // R3: 20-bit, every other cycle ready.
        alt_rdy = 1'b1; cfg_width = 2'b01;
        send(32'hFFF8_7654, 1'b0, 1'b0, "R3 20-bit a");
        send(32'h000F_FFFF, 1'b1, 1'b0, "R3 20-bit b R7");
        drain();

        // R4: 24-bit.
        cfg_width = 2'b10;
        send(32'h5512_345A, 1'b0, 1'b1, "R4 24-bit a");
        send(32'h00FF_FFFF, 1'b1, 1'b1, "R4 24-bit b R7");
        drain();

        // R5: raw pass-through, parity carried as is.
        alt_rdy = 1'b0; cfg_width = 2'b11;
        send(32'hA123_4567, 1'b0, 1'b0, "R5 raw a");
        send(32'h5FED_CBA9, 1'b1, 1'b1, "R5 raw b");
        send(32'h1000_000B, 1'b0, 1'b0, "R5 raw c");
        drain();

        // R8: packed 16-bit, left then right.
        cfg_width = 2'b00; cfg_pack = 1'b1;
        send(32'h1111_2222, 1'b1, 1'b0, "R8 packed a");
        send(32'hBEEF_0F0F, 1'b0, 1'b1, "R8 packed b");
        alt_rdy = 1'b1;
        send(32'h8000_0001, 1'b1, 1'b1, "R8 packed c");
        drain();

        // R9: packing ignored outside 16-bit.
        alt_rdy = 1'b0; cfg_width = 2'b01; cfg_pack = 1'b1;
        send(32'h1234_5678, 1'b0, 1'b0, "R9 pack ignored 20-bit");
        cfg_width = 2'b11;
        send(32'h8765_4321, 1'b0, 1'b0, "R9 pack ignored raw");
        drain();
        repeat (2) @(negedge clk);
        check("R9 no extra subframe", {31'b0, out_valid}, 32'h0);

        // R10 R11: stall on a packed word, change config while held.
        hold_low = 1'b1;
        @(negedge clk); @(negedge clk);
        cfg_width = 2'b00; cfg_pack = 1'b1;
        send(32'hCAFE_4321, 1'b1, 1'b0, "R11 captured config");
        check("R10 stalled in_ready", {31'b0, in_ready}, 32'h0);
        check("R10 stalled out_valid", {31'b0, out_valid}, 32'h1);
        held = out_audio;
        cfg_width = 2'b11; cfg_pack = 1'b0; ext_user = 1'b0; ext_chstat = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 audio stable under stall", {12'b0, out_audio}, {12'b0, held});
        check("R11 left audio after config change", {12'b0, out_audio}, 32'h43210);
        hold_low = 1'b0;
        @(negedge clk);
        check("R10 in_ready low on left half", {31'b0, in_ready}, 32'h0);
        @(negedge clk);
        check("R10 in_ready high on right half", {31'b0, in_ready}, 32'h1);
        check("R8 right half audio", {12'b0, out_audio}, 32'hCAFE0);
        drain();

        check("scoreboard empty", expq.size(), 32'h0);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule